// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This unit is the data-path core of a small 8-bit accumulator processor. Each cycle it takes a 5-bit operation code, a register operand (`opa_i`), a memory operand (`opb_i`) and the flags held in its own status register. From these it produces an 8-bit result, a strobe that says whether the result is to be written back, and the next value of every flag. The operations cover add and subtract with carry, compare, bit test, the four shift and rotate forms, increment and decrement, the three logic operations, loads and transfers, and the set and clear flag operations.

The eight flags live in one register inside the block. It loads the computed next flags on a clock edge while `flag_we_i` is high. Its packed status byte is always visible on `status_o`. A restore operation unpacks a status byte taken from the memory operand back into the flags. The decimal flag can be set and cleared, but addition is always binary.

Top module: `alu8_status`

## Requirements
- R1: Op 6 (add with carry) returns (A + B + C) mod 256 and writes it. Carry is set when the full sum exceeds 255. Overflow is set when A and B share bit 7 and the result's bit 7 differs from A's. Zero and negative follow the result.
- R2: Op 7 (subtract with carry) returns (A − B − (1 − C)) mod 256 and writes it. Carry is set when the full difference is not negative. Overflow is set when A and B differ in bit 7 and the result's bit 7 differs from A's. Zero and negative follow the result.
- R3: Op 8 (compare) sets zero and negative from (A − B) mod 256, sets carry when A ≥ B, and does not raise `res_we_o`.
- R4: Op 9 (bit test) copies B bit 6 to overflow and B bit 7 to negative, sets zero when (A AND B) is 0, changes no other flag, and does not raise `res_we_o`.
- R5: Ops 10 to 13 act on A: 10 shifts left with bit 7 going to carry, 11 shifts right with bit 0 going to carry, 12 rotates left with the old carry entering bit 0, 13 rotates right with the old carry entering bit 7. All four write the result and set zero and negative from it.
- R6: Op 0 (load B), op 1 (transfer A), op 14 (A+1), op 15 (A−1), op 3 (AND), op 4 (OR) and op 5 (XOR) write the result and set zero and negative from it. Op 2 (transfer A to the stack pointer) writes A and leaves every flag unchanged.
- R7: The status byte has carry in bit 0, zero in bit 1, interrupt-disable in bit 2, decimal in bit 3, break in bit 4, unused in bit 5, overflow in bit 6 and negative in bit 7. Op 23 (restore) loads all eight flags from B in that layout and writes no result.
- R8: Op 16 clears carry, 17 sets carry, 18 clears interrupt-disable, 19 sets interrupt-disable, 20 clears decimal, 21 sets decimal and 22 clears overflow. Each changes only its own flag and writes no result.
- R9: The flag register changes only on a clock edge with `flag_we_i` high. A set decimal flag does not change the result or the flags of op 6.
- R10: While reset is held, and after it is released, the status byte reads 0x24 until the first flag write.
- R11: Op codes 24 to 31 write no result and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_i | input | 5 | Operation code |
| opa_i | input | 8 | Register operand |
| opb_i | input | 8 | Memory operand |
| flag_we_i | input | 1 | Loads the next flags into the status register on the clock edge |
| result_o | output | 8 | Operation result |
| res_we_o | output | 1 | Result is to be written back |
| flags_nx_o | output | 8 | Next flags, packed as the status byte |
| status_o | output | 8 | Current flags, packed as the status byte |

## Verification
A wrong bit in the status register shows on `status_o` in the cycle after the bad write. It also shows in the same cycle on `flags_nx_o`, because every operation that leaves a flag alone passes it straight through. A carry held wrongly shifts every later add, subtract and rotate by one bit or one unit, so such a fault surfaces at the very next arithmetic step. For that reason the bench chains operations without re-seeding the flags, and compares results, strobe, next flags and stored status against its own model on every clock.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_LDB     = 5'd0,
    OP_MOVA    = 5'd1,
    OP_MOVSP   = 5'd2,
    OP_AND     = 5'd3,
    OP_OR      = 5'd4,
    OP_XOR     = 5'd5,
    OP_ADC     = 5'd6,
    OP_SBC     = 5'd7,
    OP_CMP     = 5'd8,
    OP_BIT     = 5'd9,
    OP_SHL     = 5'd10,
    OP_SHR     = 5'd11,
    OP_ROL     = 5'd12,
    OP_ROR     = 5'd13,
    OP_INC     = 5'd14,
    OP_DEC     = 5'd15,
    OP_CLC     = 5'd16,
    OP_SEC     = 5'd17,
    OP_CLI     = 5'd18,
    OP_SEI     = 5'd19,
    OP_CLD     = 5'd20,
    OP_SED     = 5'd21,
    OP_CLV     = 5'd22,
    OP_RESTORE = 5'd23
  } alu_op_e;

  // Member order fixes the packed status layout: c is bit 0, n is bit 7.
  typedef struct packed {
    logic n;
    logic v;
    logic u;
    logic b;
    logic d;
    logic i;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;

  // Subtraction adds the inverted operand; the carry then acts as "no borrow".
  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
    sum_o  = full[MSB:0];
    cout_o = full[WIDTH];
    ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             right_i,
  input  logic             fill_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    if (right_i) begin
      res_o  = {fill_i, a_i[MSB:1]};
      cout_o = a_i[0];
    end else begin
      res_o  = {a_i[MSB-1:0], fill_i};
      cout_o = a_i[MSB];
    end
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg #(
  parameter int         WIDTH     = 8,
  parameter logic [7:0] RESET_VAL = 8'h24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic             rst_meta;
  logic             rst_sync;
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nx;

  // Reset asserts at once and releases two clock edges after rst_n rises.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  always_comb begin
    q_nx = q_r;
    if (we_i) q_nx = d_i;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) q_r <= RESET_VAL[WIDTH-1:0];
    else           q_r <= q_nx;
  end

  assign q_o = q_r;

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_sync)
    !we_i |=> $stable(q_o));

  p_flag_load_r9: assert property (@(posedge clk) disable iff (!rst_sync)
    we_i |=> (q_o == $past(d_i)));
endmodule

// File: rtl/alu8_status.sv
module alu8_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] op_i,
  input  logic [7:0] opa_i,
  input  logic [7:0] opb_i,
  input  logic       flag_we_i,
  output logic [7:0] result_o,
  output logic       res_we_o,
  output logic [7:0] flags_nx_o,
  output logic [7:0] status_o
);
  import alu8_pkg::*;

  localparam int         DW        = 8;
  localparam int         MSB       = DW - 1;
  localparam logic [7:0] RESET_VAL = 8'h24;

  alu_op_e          op;
  flags_t           fl;
  flags_t           fl_nx;
  logic [DW-1:0]    res;
  logic             res_we;

  logic [DW-1:0]    as_sum;
  logic             as_cout;
  logic             as_ovf;
  logic             as_sub;
  logic             as_cin;
  logic [DW-1:0]    sh_res;
  logic             sh_cout;
  logic             sh_right;
  logic             sh_fill;
  logic [DW-1:0]    status_q;

  assign op = alu_op_e'(op_i);
  assign fl = flags_t'(status_q);

  // Compare is a subtract with forced carry-in of one.
  assign as_sub   = (op != OP_ADC);
  assign as_cin   = (op == OP_CMP) ? 1'b1 : fl.c;
  assign sh_right = (op == OP_SHR) || (op == OP_ROR);
  assign sh_fill  = ((op == OP_ROL) || (op == OP_ROR)) ? fl.c : 1'b0;

  alu8_addsub #(.WIDTH(DW)) u_addsub (
    .a_i    (opa_i),
    .b_i    (opb_i),
    .sub_i  (as_sub),
    .cin_i  (as_cin),
    .sum_o  (as_sum),
    .cout_o (as_cout),
    .ovf_o  (as_ovf)
  );

  alu8_shift #(.WIDTH(DW)) u_shift (
    .a_i     (opa_i),
    .right_i (sh_right),
    .fill_i  (sh_fill),
    .res_o   (sh_res),
    .cout_o  (sh_cout)
  );

  always_comb begin
    res    = opa_i;
    res_we = 1'b0;
    fl_nx  = fl;
    case (op)
      OP_LDB:   begin res = opb_i; res_we = 1'b1; end
      OP_MOVA:  begin res = opa_i; res_we = 1'b1; end
      OP_MOVSP: begin res = opa_i; res_we = 1'b1; end
      OP_AND:   begin res = opa_i & opb_i; res_we = 1'b1; end
      OP_OR:    begin res = opa_i | opb_i; res_we = 1'b1; end
      OP_XOR:   begin res = opa_i ^ opb_i; res_we = 1'b1; end
      OP_INC:   begin res = opa_i + 8'd1; res_we = 1'b1; end
      OP_DEC:   begin res = opa_i - 8'd1; res_we = 1'b1; end
      OP_ADC, OP_SBC: begin
        res = as_sum; res_we = 1'b1;
        fl_nx.c = as_cout;
        fl_nx.v = as_ovf;
      end
      OP_CMP: begin res = as_sum; fl_nx.c = as_cout; end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res = sh_res; res_we = 1'b1;
        fl_nx.c = sh_cout;
      end
      OP_BIT: begin
        res     = opa_i & opb_i;
        fl_nx.v = opb_i[MSB-1];
      end
      OP_CLC: fl_nx.c = 1'b0;
      OP_SEC: fl_nx.c = 1'b1;
      OP_CLI: fl_nx.i = 1'b0;
      OP_SEI: fl_nx.i = 1'b1;
      OP_CLD: fl_nx.d = 1'b0;
      OP_SED: fl_nx.d = 1'b1;
      OP_CLV: fl_nx.v = 1'b0;
      OP_RESTORE: fl_nx = flags_t'(opb_i);
      default: ;
    endcase

    // Zero and negative: every op that forms a value, bar the stack transfer.
    case (op)
      OP_LDB, OP_MOVA, OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC,
      OP_ADC, OP_SBC, OP_CMP, OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        fl_nx.z = (res == '0);
        fl_nx.n = res[MSB];
      end
      OP_BIT: begin
        fl_nx.z = (res == '0);
        fl_nx.n = opb_i[MSB];
      end
      default: ;
    endcase
  end

  alu8_flagreg #(.WIDTH(DW), .RESET_VAL(RESET_VAL)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .we_i  (flag_we_i),
    .d_i   (fl_nx),
    .q_o   (status_q)
  );

  assign result_o   = res;
  assign res_we_o   = res_we;
  assign flags_nx_o = fl_nx;
  assign status_o   = status_q;

  p_add_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 5'd6 && opa_i[7] != opb_i[7]) |-> !flags_nx_o[6]);

  p_sub_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 5'd7 && opa_i[7] == opb_i[7]) |-> !flags_nx_o[6]);

  p_cmp_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 5'd8) |-> (!res_we_o && flags_nx_o[0] == (opa_i >= opb_i)));

  p_bit_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 5'd9) |-> (flags_nx_o[7:6] == opb_i[7:6] && !res_we_o));

  p_sp_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 5'd2) |-> (flags_nx_o == status_o && result_o == opa_i));

  p_spare_ops_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= 5'd24) |-> (!res_we_o && flags_nx_o == status_o));
endmodule

// File: tb/test_alu8_status.sv
`timescale 1ns/1ps
module test_alu8_status;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] op;
  logic [7:0] a, b;
  logic       fwe;
  logic [7:0] result_o, flags_nx_o, status_o;
  logic       res_we_o;

  int checks   = 0;
  int failures = 0;
  int mflags;

  always #5 clk = ~clk;

  alu8_status i_alu8_status (
    .clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(a), .opb_i(b),
    .flag_we_i(fwe), .result_o(result_o), .res_we_o(res_we_o),
    .flags_nx_o(flags_nx_o), .status_o(status_o)
  );

  function automatic string req_of(input int o);
    if (o == 6) return "R1";
    if (o == 7) return "R2";
    if (o == 8) return "R3";
    if (o == 9) return "R4";
    if (o >= 10 && o <= 13) return "R5";
    if (o <= 5 || o == 14 || o == 15) return "R6";
    if (o == 23) return "R7";
    if (o >= 16 && o <= 22) return "R8";
    return "R11";
  endfunction

  // Behavioural model; flags as an int with carry at bit 0 ... negative at bit 7.
  function automatic void model(input int o, input int x, input int y, input int f,
                                output int r, output int w, output int nf);
    int c, t, zn;
    c  = f & 1;
    r  = x; w = 0; nf = f; zn = 1;
    case (o)
      0: begin r = y; w = 1; end
      1: begin r = x; w = 1; end
      2: begin r = x; w = 1; zn = 0; end
      3: begin r = x & y; w = 1; end
      4: begin r = x | y; w = 1; end
      5: begin r = x ^ y; w = 1; end
      6: begin
        t = x + y + c; r = t % 256; w = 1;
        nf = (nf & ~1) | (t > 255 ? 1 : 0);
        nf = (nf & ~64) | ((((x ^ y) & 128) == 0 && ((x ^ r) & 128) != 0) ? 64 : 0);
      end
      7: begin
        t = x - y - (1 - c); r = (t + 512) % 256; w = 1;
        nf = (nf & ~1) | (t >= 0 ? 1 : 0);
        nf = (nf & ~64) | ((((x ^ y) & 128) != 0 && ((x ^ r) & 128) != 0) ? 64 : 0);
      end
      8: begin r = (x - y + 256) % 256; nf = (nf & ~1) | (x >= y ? 1 : 0); end
      9: begin
        zn = 0;
        nf = (nf & ~(128 | 64 | 2)) | (y & 192) | (((x & y) == 0) ? 2 : 0);
      end
      10: begin r = (x * 2) % 256; w = 1; nf = (nf & ~1) | (x / 128); end
      11: begin r = x / 2; w = 1; nf = (nf & ~1) | (x % 2); end
      12: begin r = (x * 2) % 256 + c; w = 1; nf = (nf & ~1) | (x / 128); end
      13: begin r = x / 2 + c * 128; w = 1; nf = (nf & ~1) | (x % 2); end
      14: begin r = (x + 1) % 256; w = 1; end
      15: begin r = (x + 255) % 256; w = 1; end
      16: nf = f & ~1;
      17: nf = f | 1;
      18: nf = f & ~4;
      19: nf = f | 4;
      20: nf = f & ~8;
      21: nf = f | 8;
      22: nf = f & ~64;
      23: nf = y;
      default: ;
    endcase
    if (o >= 16 || o == 2) zn = 0;
    if (zn == 1) nf = (nf & ~(128 | 2)) | (r & 128) | ((r == 0) ? 2 : 0);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int o, input int x, input int y, input bit we);
    int r, w, nf;
    string rq;
    @(negedge clk);
    op = o[4:0]; a = x[7:0]; b = y[7:0]; fwe = we;
    model(o, x, y, mflags, r, w, nf);
    rq = req_of(o);
    #1;
    chk(rq, "res_we", int'(res_we_o), w);
    if (w == 1) chk(rq, "result", int'(result_o), r);
    chk(rq, "flags_nx", int'(flags_nx_o), nf);
    @(posedge clk);
    #1;
    if (we) mflags = nf;
    chk(we ? rq : "R9", "status", int'(status_o), mflags);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op = 5'd31; a = '0; b = '0; fwe = 1'b0;
    mflags = 8'h24;
    repeat (3) @(posedge clk);
    #1 chk("R10", "status in reset", int'(status_o), 8'h24);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 chk("R10", "status after release", int'(status_o), 8'h24);

    // R1: add with carry, including carry chained from the previous step
    step(16, 0, 0, 1);
    step(6, 8'h50, 8'h50, 1);
    step(6, 8'hFF, 8'h01, 1);
    step(6, 8'h7F, 8'h00, 1);
    step(6, 8'h80, 8'h80, 1);
    step(6, 8'h10, 8'h20, 1);
    // R9: decimal flag set, addition stays binary
    step(21, 0, 0, 1);
    step(6, 8'h09, 8'h01, 1);
    step(20, 0, 0, 1);
    // R2: subtract with borrow
    step(17, 0, 0, 1);
    step(7, 8'h50, 8'hB0, 1);
    step(7, 8'h00, 8'h01, 1);
    step(7, 8'h05, 8'h03, 1);
    step(7, 8'h80, 8'h01, 1);
    // R3: compare equal, less, greater
    step(8, 8'h42, 8'h42, 1);
    step(8, 8'h10, 8'h20, 1);
    step(8, 8'hF0, 8'h01, 1);
    // R4: bit test
    step(9, 8'h3F, 8'hC0, 1);
    step(9, 8'h01, 8'h01, 1);
    // R5: shifts and rotates, carry threaded through
    step(10, 8'h81, 0, 1);
    step(12, 8'h40, 0, 1);
    step(13, 8'h01, 0, 1);
    step(13, 8'h00, 0, 1);
    step(11, 8'h01, 0, 1);
    // R6: zero/negative producers and the stack transfer
    step(0, 0, 8'h80, 1);
    step(1, 8'h00, 0, 1);
    step(14, 8'hFF, 0, 1);
    step(15, 8'h00, 0, 1);
    step(3, 8'hF0, 8'h0F, 1);
    step(4, 8'h80, 8'h01, 1);
    step(5, 8'hAA, 8'hAA, 1);
    step(2, 8'h00, 0, 1);
    // R7: restore from a status byte, then more flag ops on it
    step(23, 0, 8'hC3, 1);
    step(23, 0, 8'h3C, 1);
    // R8: set and clear operations
    step(19, 0, 0, 1);
    step(18, 0, 0, 1);
    step(17, 0, 0, 1);
    step(23, 0, 8'h40, 1);
    step(22, 0, 0, 1);
    // R9: flag write disabled leaves the register untouched
    step(6, 8'hFF, 8'hFF, 0);
    step(23, 0, 8'hFF, 0);
    // R11: spare op codes
    step(24, 8'h00, 8'h00, 1);
    step(31, 8'h80, 8'h80, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule